// File: doc/BRIEF.md
# Mode-Banked Register Switch

This block keeps the per-mode copies of the stack pointer (r13), link register (r14) and saved-status word for a processor with seven operating modes. It also holds a second copy of r8–r12 that only the fast-interrupt mode uses. The rest of the core sees one visible set of r8–r14 plus the saved-status word, reached through a write port and a read port. When software or exception logic asks for a mode change, the block stores the outgoing mode's visible copies and brings in the incoming mode's copies. The visible set then always belongs to the current mode.

A mode change is a valid/ready request carrying a 5-bit mode code. `sw_ready` is high while the block is idle. A request is taken on a clock edge where `sw_valid` and `sw_ready` are both high. In the next cycle `sw_ready` is low, and the swap completes on the following edge. A requester holding `sw_valid` high simply waits. Writes use the same back-pressure: `wr_ready` falls together with `sw_ready`, so no write can land while a swap is pending. Reads are combinational and always available.

A request for the current mode changes nothing. A request with an unknown mode code leaves all state alone and raises `err_o` for one cycle.

Top module: `mbank_switch`

## Requirements
- R1: After reset the current mode is supervisor (0x13), all eight visible slots and every bank and shadow word read as zero, `sw_ready` and `wr_ready` are 1 and `err_o` is 0.
- R2: Mode codes are user 0x10, fast interrupt 0x11, normal interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. Each mode keeps its own r13/r14/status copy, except that user and system share one.
- R3: A switch request is taken on an edge with `sw_valid` and `sw_ready` high. `sw_ready` is 0 for exactly the next cycle. The new mode and its visible registers appear after the following edge. A strobe presented while `sw_ready` is 0 is not taken.
- R4: On a switch between different modes, the visible r13, r14 and status word are stored into the old mode's copy, and the visible ones are then loaded from the new mode's copy.
- R5: Switching between user and system mode leaves the visible r13, r14 and status word unchanged.
- R6: Entering fast-interrupt mode from any other mode stores visible r8–r12 in the user shadow set and loads them from the fast-interrupt shadow set.
- R7: Leaving fast-interrupt mode stores visible r8–r12 in the fast-interrupt shadow set and loads them from the user shadow set.
- R8: A switch in which neither the old nor the new mode is fast interrupt leaves visible r8–r12 unchanged.
- R9: A request for the mode already current changes no register and does not raise `err_o`.
- R10: A request with any other code raises `err_o` for exactly one cycle, in the cycle where a legal switch would have completed. The mode and all registers stay unchanged.
- R11: A write with `wr_valid` and `wr_ready` high stores `wr_data` into the visible slot named by `wr_sel`. The slot codes are 0–4 for r8–r12, 5 for r13, 6 for r14 and 7 for the status word. `rd_data` shows the slot named by `rd_sel` using the same codes. A write offered while `wr_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_valid | input | 1 | Mode switch request valid |
| sw_ready | output | 1 | Block can accept a switch request |
| sw_mode | input | 5 | Requested mode code |
| wr_valid | input | 1 | Visible-register write valid |
| wr_ready | output | 1 | Block can accept a write |
| wr_sel | input | 3 | Slot to write |
| wr_data | input | DW | Write data |
| rd_sel | input | 3 | Slot to read |
| rd_data | output | DW | Read data for `rd_sel` |
| mode_o | output | 5 | Current mode code |
| err_o | output | 1 | One-cycle pulse for an unknown requested mode |

## Verification
The bench goes after the shared user/system copy. A design that loaded the stale stored value there, instead of the value just saved, would lose r13/r14 on that switch. It enters and leaves fast-interrupt mode so that both shadow directions are used; swapping the wrong set, or swapping on ordinary switches, shows up as wrong r8–r12. It also sends a same-mode request and an unknown code: a design that treated either as a real switch would clobber the current mode's copy or change `mode_o`. A strobe and a write are offered in the busy cycle; accepting either would change the mode a second time or corrupt a visible register.

// File: rtl/mbank_pkg.sv
package mbank_pkg;
  localparam int MODE_W   = 5;
  localparam int NUM_BANK = 6;
  localparam int BANK_W   = $clog2(NUM_BANK);
  localparam int NUM_GP   = 5;
  localparam int SLOT_W   = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_USR = 5'h10,
    MD_FIQ = 5'h11,
    MD_IRQ = 5'h12,
    MD_SVC = 5'h13,
    MD_ABT = 5'h17,
    MD_UND = 5'h1B,
    MD_SYS = 5'h1F
  } mode_e;
endpackage

// File: rtl/mbank_mode_decode.sv
module mbank_mode_decode
  import mbank_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              legal_o,
  output logic              is_fiq_o
);
  always_comb begin
    legal_o  = 1'b1;
    is_fiq_o = 1'b0;
    bank_o   = '0;
    case (mode_i)
      MD_USR, MD_SYS: bank_o = BANK_W'(0);
      MD_SVC:         bank_o = BANK_W'(1);
      MD_ABT:         bank_o = BANK_W'(2);
      MD_UND:         bank_o = BANK_W'(3);
      MD_IRQ:         bank_o = BANK_W'(4);
      MD_FIQ: begin
        bank_o   = BANK_W'(5);
        is_fiq_o = 1'b1;
      end
      default:        legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mbank_bank_store.sv
module mbank_bank_store
  import mbank_pkg::*;
#(
  parameter int DW = 32,
  parameter int NB = NUM_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_en,
  input  logic [BANK_W-1:0] save_idx,
  input  logic [DW-1:0]     save_sp,
  input  logic [DW-1:0]     save_lr,
  input  logic [DW-1:0]     save_sts,
  input  logic [BANK_W-1:0] load_idx,
  output logic [DW-1:0]     load_sp,
  output logic [DW-1:0]     load_lr,
  output logic [DW-1:0]     load_sts
);
  logic [DW-1:0] sp_q  [NB];
  logic [DW-1:0] lr_q  [NB];
  logic [DW-1:0] sts_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sp_q[b]  <= '0;
        lr_q[b]  <= '0;
        sts_q[b] <= '0;
      end else if (save_en && save_idx == BANK_W'(b)) begin
        sp_q[b]  <= save_sp;
        lr_q[b]  <= save_lr;
        sts_q[b] <= save_sts;
      end
    end
  end

  // Save happens before load: a shared bank hands back the value being saved.
  logic same_bank;
  assign same_bank = save_en && (save_idx == load_idx);

  always_comb begin
    load_sp  = '0;
    load_lr  = '0;
    load_sts = '0;
    if (same_bank) begin
      load_sp  = save_sp;
      load_lr  = save_lr;
      load_sts = save_sts;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (load_idx == BANK_W'(b)) begin
          load_sp  = sp_q[b];
          load_lr  = lr_q[b];
          load_sts = sts_q[b];
        end
      end
    end
  end

  p_save_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    save_en |-> (int'(save_idx) < NB));
  p_saved_value_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    save_en |=> (sp_q[$past(save_idx)] == $past(save_sp)));
endmodule

// File: rtl/mbank_shadow.sv
module mbank_shadow
  import mbank_pkg::*;
#(
  parameter int DW = 32,
  parameter int NG = NUM_GP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_usr,
  input  logic             save_fiq,
  input  logic [NG*DW-1:0] vis_i,
  output logic [NG*DW-1:0] usr_o,
  output logic [NG*DW-1:0] fiq_o
);
  logic [DW-1:0] usr_q [NG];
  logic [DW-1:0] fiq_q [NG];

  for (genvar g = 0; g < NG; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        usr_q[g] <= '0;
        fiq_q[g] <= '0;
      end else begin
        if (save_usr) usr_q[g] <= vis_i[g*DW +: DW];
        if (save_fiq) fiq_q[g] <= vis_i[g*DW +: DW];
      end
    end
    assign usr_o[g*DW +: DW] = usr_q[g];
    assign fiq_o[g*DW +: DW] = fiq_q[g];
  end

  p_one_shadow_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(save_usr && save_fiq));
  p_usr_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !save_usr |=> $stable(usr_o));
endmodule

// File: rtl/mbank_switch.sv
module mbank_switch
  import mbank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_valid,
  output logic              sw_ready,
  input  logic [MODE_W-1:0] sw_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [SLOT_W-1:0] wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic [SLOT_W-1:0] rd_sel,
  output logic [DW-1:0]     rd_data,
  output logic [MODE_W-1:0] mode_o,
  output logic              err_o
);
  localparam int GPW      = NUM_GP * DW;
  localparam int SLOT_SP  = NUM_GP;
  localparam int SLOT_LR  = NUM_GP + 1;
  localparam int SLOT_STS = NUM_GP + 2;

  logic              busy_q, err_q;
  logic [MODE_W-1:0] mode_q, pend_q;
  logic [DW-1:0]     vis_gp [NUM_GP];
  logic [DW-1:0]     vis_sp, vis_lr, vis_sts;
  logic [GPW-1:0]    vis_gp_flat, usr_sh, fiq_sh;

  logic [BANK_W-1:0] cur_bank, new_bank;
  logic              cur_legal, new_legal, cur_fiq, new_fiq;
  logic [DW-1:0]     ld_sp, ld_lr, ld_sts;

  logic accept, wr_fire, do_swap, save_usr, save_fiq;

  assign sw_ready = !busy_q;
  assign wr_ready = !busy_q;
  assign accept   = sw_valid && !busy_q;
  assign wr_fire  = wr_valid && !busy_q;
  assign do_swap  = busy_q && new_legal && (pend_q != mode_q);
  assign save_fiq = do_swap && cur_fiq;
  assign save_usr = do_swap && !cur_fiq && new_fiq;
  assign mode_o   = mode_q;
  assign err_o    = err_q;

  for (genvar g = 0; g < NUM_GP; g++) begin : g_flat
    assign vis_gp_flat[g*DW +: DW] = vis_gp[g];
  end

  mbank_mode_decode u_dec_cur (
    .mode_i  (mode_q),
    .bank_o  (cur_bank),
    .legal_o (cur_legal),
    .is_fiq_o(cur_fiq)
  );

  mbank_mode_decode u_dec_new (
    .mode_i  (pend_q),
    .bank_o  (new_bank),
    .legal_o (new_legal),
    .is_fiq_o(new_fiq)
  );

  mbank_bank_store #(.DW(DW), .NB(NUM_BANK)) u_banks (
    .clk     (clk),
    .rst_n   (rst_n),
    .save_en (do_swap),
    .save_idx(cur_bank),
    .save_sp (vis_sp),
    .save_lr (vis_lr),
    .save_sts(vis_sts),
    .load_idx(new_bank),
    .load_sp (ld_sp),
    .load_lr (ld_lr),
    .load_sts(ld_sts)
  );

  mbank_shadow #(.DW(DW), .NG(NUM_GP)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .save_usr(save_usr),
    .save_fiq(save_fiq),
    .vis_i   (vis_gp_flat),
    .usr_o   (usr_sh),
    .fiq_o   (fiq_sh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      mode_q  <= MD_SVC;
      pend_q  <= MD_SVC;
      vis_sp  <= '0;
      vis_lr  <= '0;
      vis_sts <= '0;
      for (int g = 0; g < NUM_GP; g++) vis_gp[g] <= '0;
    end else begin
      busy_q <= accept;
      err_q  <= busy_q && !new_legal;
      if (accept) pend_q <= sw_mode;
      if (do_swap) begin
        mode_q  <= pend_q;
        vis_sp  <= ld_sp;
        vis_lr  <= ld_lr;
        vis_sts <= ld_sts;
        if (cur_fiq) begin
          for (int g = 0; g < NUM_GP; g++) vis_gp[g] <= usr_sh[g*DW +: DW];
        end else if (new_fiq) begin
          for (int g = 0; g < NUM_GP; g++) vis_gp[g] <= fiq_sh[g*DW +: DW];
        end
      end else if (wr_fire) begin
        if (int'(wr_sel) < NUM_GP) vis_gp[wr_sel] <= wr_data;
        else if (int'(wr_sel) == SLOT_SP) vis_sp <= wr_data;
        else if (int'(wr_sel) == SLOT_LR) vis_lr <= wr_data;
        else vis_sts <= wr_data;
      end
    end
  end

  always_comb begin
    if (int'(rd_sel) < NUM_GP)         rd_data = vis_gp[rd_sel];
    else if (int'(rd_sel) == SLOT_SP)  rd_data = vis_sp;
    else if (int'(rd_sel) == SLOT_LR)  rd_data = vis_lr;
    else                               rd_data = vis_sts;
  end

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_legal);
  p_one_cycle_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);
  p_ready_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && sw_ready) |=> !sw_ready);
  p_gp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_swap && !cur_fiq && !new_fiq) |=> $stable(vis_gp_flat));
  p_same_mode_noop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pend_q == mode_q) |=>
      ($stable(vis_sp) && $stable(vis_lr) && $stable(vis_sts) && !err_o));
  p_bad_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ($stable(mode_o) && $stable(vis_sp) && $stable(vis_gp_flat)));
  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
endmodule

// File: tb/mbank_switch_tb_top.sv
module mbank_switch_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sw_valid, sw_ready, wr_valid, wr_ready, err_o;
  logic [4:0]    sw_mode, mode_o;
  logic [2:0]    wr_sel, rd_sel;
  logic [DW-1:0] wr_data, rd_data;

  always #2 clk = ~clk;

  mbank_switch #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_mode(sw_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mode_o(mode_o), .err_o(err_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic [2:0]    sel;
    logic [DW-1:0] val;
    string         tag;
  } exp_t;
  exp_t exp_q[$];
  bit   mon_busy = 0;

  // Reference state, built from the requirements
  logic [DW-1:0] m_vis  [8];
  logic [DW-1:0] m_bank [6][3];
  logic [DW-1:0] m_usr  [5];
  logic [DW-1:0] m_fiq  [5];
  logic [4:0]    m_mode;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit legal(input logic [4:0] m);
    return m inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
  endfunction

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'h10, 5'h1F: return 0;
      5'h13: return 1;
      5'h17: return 2;
      5'h1B: return 3;
      5'h12: return 4;
      default: return 5;
    endcase
  endfunction

  // Monitor: drives rd_sel and compares against the scoreboard queue
  initial begin
    exp_t it;
    rd_sel = '0;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        mon_busy = 1;
        it = exp_q.pop_front();
        rd_sel = it.sel;
        #1;
        chk(rd_data === it.val, it.tag, rd_data, it.val);
        mon_busy = 0;
      end
    end
  end

  task automatic push_all(input string tag);
    for (int s = 0; s < 8; s++) begin
      exp_t e;
      e.sel = 3'(s);
      e.val = m_vis[s];
      e.tag = tag;
      exp_q.push_back(e);
    end
    wait (exp_q.size() == 0 && mon_busy == 0);
  endtask

  task automatic do_write(input int sel, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1; wr_sel = 3'(sel); wr_data = d;
    chk(wr_ready === 1'b1, "R11 wr_ready idle", 32'(wr_ready), 1);
    @(negedge clk);
    wr_valid = 0;
    m_vis[sel] = d;
  endtask

  task automatic model_switch(input logic [4:0] nm);
    int ob, nb;
    if (!legal(nm) || nm == m_mode) return;
    ob = bank_of(m_mode);
    nb = bank_of(nm);
    for (int k = 0; k < 3; k++) m_bank[ob][k] = m_vis[5+k];
    for (int k = 0; k < 3; k++) m_vis[5+k] = m_bank[nb][k];
    if (m_mode == 5'h11) begin
      for (int k = 0; k < 5; k++) begin m_fiq[k] = m_vis[k]; m_vis[k] = m_usr[k]; end
    end else if (nm == 5'h11) begin
      for (int k = 0; k < 5; k++) begin m_usr[k] = m_vis[k]; m_vis[k] = m_fiq[k]; end
    end
    m_mode = nm;
  endtask

  // poke: offer a second strobe and a write in the busy cycle (R3, R11)
  task automatic do_switch(input logic [4:0] nm, input bit poke, input string tag);
    bit bad;
    bad = !legal(nm);
    @(negedge clk);
    sw_valid = 1; sw_mode = nm;
    chk(sw_ready === 1'b1, {tag, " R3 ready before"}, 32'(sw_ready), 1);
    @(negedge clk);
    sw_valid = 0;
    chk(sw_ready === 1'b0, {tag, " R3 ready low busy"}, 32'(sw_ready), 0);
    chk(wr_ready === 1'b0, {tag, " R11 wr_ready low busy"}, 32'(wr_ready), 0);
    chk(mode_o === m_mode, {tag, " R3 mode not yet"}, 32'(mode_o), 32'(m_mode));
    if (poke) begin
      sw_valid = 1; sw_mode = 5'h1B;
      wr_valid = 1; wr_sel = 3'd0; wr_data = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    sw_valid = 0; wr_valid = 0;
    model_switch(nm);
    chk(mode_o === m_mode, {tag, " R3 mode after"}, 32'(mode_o), 32'(m_mode));
    chk(err_o === bad, {tag, " R10 err flag"}, 32'(err_o), 32'(bad));
    chk(sw_ready === 1'b1, {tag, " R3 ready back"}, 32'(sw_ready), 1);
    @(negedge clk);
    chk(err_o === 1'b0, {tag, " R10 err one cycle"}, 32'(err_o), 0);
    if (poke) begin
      chk(sw_ready === 1'b1, {tag, " R3 poke strobe not taken"}, 32'(sw_ready), 1);
      chk(mode_o === m_mode, {tag, " R3 poke mode held"}, 32'(mode_o), 32'(m_mode));
    end
    push_all(tag);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=0", 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sw_valid = 0; sw_mode = 5'h13; wr_valid = 0; wr_sel = 0; wr_data = 0;
    for (int s = 0; s < 8; s++) m_vis[s] = '0;
    for (int b = 0; b < 6; b++) for (int k = 0; k < 3; k++) m_bank[b][k] = '0;
    for (int k = 0; k < 5; k++) begin m_usr[k] = '0; m_fiq[k] = '0; end
    m_mode = 5'h13;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(mode_o === 5'h13, "R1 mode", 32'(mode_o), 32'h13);
    chk(sw_ready === 1'b1, "R1 sw_ready", 32'(sw_ready), 1);
    chk(wr_ready === 1'b1, "R1 wr_ready", 32'(wr_ready), 1);
    chk(err_o === 1'b0, "R1 err", 32'(err_o), 0);
    push_all("R1 regs zero");

    // R11 writes in supervisor mode
    for (int s = 0; s < 8; s++) do_write(s, 32'h100 + 32'(s));
    push_all("R11 writes");

    do_switch(5'h12, 0, "R4 R8 svc->irq");
    for (int s = 5; s < 8; s++) do_write(s, 32'h200 + 32'(s));
    do_switch(5'h13, 0, "R2 R4 irq->svc");
    do_switch(5'h11, 0, "R6 svc->fiq");
    for (int s = 0; s < 8; s++) do_write(s, 32'h300 + 32'(s));
    do_switch(5'h10, 0, "R7 fiq->usr");
    for (int s = 5; s < 8; s++) do_write(s, 32'h400 + 32'(s));
    do_switch(5'h1F, 0, "R5 usr->sys");
    do_switch(5'h1F, 0, "R9 same mode");
    do_switch(5'h15, 0, "R10 bad code");
    do_switch(5'h11, 0, "R6 sys->fiq");
    do_switch(5'h17, 1, "R3 R11 fiq->abt poke");
    do_switch(5'h1B, 0, "R8 abt->und");
    do_switch(5'h10, 0, "R5 und->usr");
    do_switch(5'h13, 0, "R2 usr->svc");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule